// File: doc/BRIEF.md
# Key-Sequence Write-Unlock Guard

This block protects the write-enable bit that guards a clock's time registers. It watches a simple write bus. Software unlocks the guard by writing two key values, in order, to a dedicated key address. The guarded bit in the control register may then be set, but only by a control write in the single cycle right after the second key. Any other attempt to set the bit is dropped without notice.

Clearing the guarded bit is always allowed. All other control bits are written normally. While the guarded bit is set, writes to the time register address are passed on as a write strobe. While it is clear, those writes are blocked.

Top module: `wr_unlock_guard`

## Requirements
- R1: After reset, `ctrl_o` is all zero, `time_wr_en_o` is clear and the key sequence is idle.
- R2: The sequence advances when the low 8 bits of the data written to the key address are 0x55, then 0x55 is followed by 0xAA. The upper data bits are ignored. Cycles with no bus write may separate the two key writes.
- R3: Writing a 1 to control bit 13 sets `time_wr_en_o` only when that write comes in the cycle right after the 0xAA key write. Otherwise bit 13 keeps its previous value.
- R4: The sequence is aborted by any of the following: a key write after 0x55 whose value is neither 0xAA nor 0x55, or any write to another address between the two keys. A write of 0x55 restarts the sequence. The unlock window closes after one cycle, so a new full sequence is then needed.
- R5: A control write with bit 13 at 0 clears the guarded bit at any time, without a key sequence.
- R6: Control bits other than bit 13 take the written data on every control write, whether the guard is locked or unlocked.
- R7: `time_we_o` is high in the same cycle as a bus write to the time address, and only while the guarded bit is set.
- R8: Writes to the key address never change `ctrl_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 4 | Bus write address (0 control, 1 key, 2 time) |
| wr_data_i | input | 16 | Bus write data |
| ctrl_o | output | 16 | Control register contents |
| time_wr_en_o | output | 1 | Guarded write-enable bit (control bit 13) |
| time_we_o | output | 1 | Gated write strobe to the time register |

## Verification
The bench builds the block with its default parameters: 16-bit data, 4-bit addresses, keys 0x55 and 0xAA, and guard bit 13. The 8-bit key width lets the bench sweep every value for both the first key and the second key. It also sweeps idle gaps both between the keys and between the second key and the control write. Further sweeps cover control data patterns in the locked and unlocked states, and time-address writes in both states of the guarded bit.

// File: rtl/wr_unlock_pkg.sv
package wr_unlock_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_FIRST = 2'd1,
    SEQ_OPEN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/wr_unlock_key_fsm.sv
module wr_unlock_key_fsm
  import wr_unlock_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned KEY_W    = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 4'h1,
  parameter logic [KEY_W-1:0] KEY_A = 8'h55,
  parameter logic [KEY_W-1:0] KEY_B = 8'hAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              open_o
);
  seq_state_e state_q, state_d;
  logic key_wr;
  logic [KEY_W-1:0] key_val;

  assign key_wr  = wr_en_i && (wr_addr_i == KEY_ADDR);
  assign key_val = wr_data_i[KEY_W-1:0];

  always_comb begin
    state_d = state_q;
    if (wr_en_i) begin
      if (!key_wr)                                  state_d = SEQ_IDLE;
      else if (key_val == KEY_A)                    state_d = SEQ_FIRST;
      else if (state_q == SEQ_FIRST && key_val == KEY_B) state_d = SEQ_OPEN;
      else                                          state_d = SEQ_IDLE;
    end else if (state_q == SEQ_OPEN) begin
      state_d = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign open_o = (state_q == SEQ_OPEN);

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |-> $past(key_wr && key_val == KEY_B)); // R2
  AST_WINDOW_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |=> !open_o); // R4
endmodule

// File: rtl/wr_unlock_ctrl_reg.sv
module wr_unlock_ctrl_reg #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned GUARD_BIT = 13,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              open_i,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam logic [DATA_W-1:0] GUARD_MASK = DATA_W'(1) << GUARD_BIT;

  logic              ctrl_wr;
  logic [DATA_W-1:0] ctrl_q, ctrl_d;

  assign ctrl_wr = wr_en_i && (wr_addr_i == CTRL_ADDR);

  always_comb begin
    ctrl_d = wr_data_i;
    // set needs the open window; clear always passes
    ctrl_d[GUARD_BIT] = wr_data_i[GUARD_BIT] && (ctrl_q[GUARD_BIT] || open_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;

  AST_SET_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_q[GUARD_BIT]) |-> $past(open_i && ctrl_wr)); // R3
  AST_CLEAR_ANYTIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !wr_data_i[GUARD_BIT]) |=> !ctrl_q[GUARD_BIT]); // R5
  AST_OTHER_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> ((ctrl_q & ~GUARD_MASK) == ($past(wr_data_i) & ~GUARD_MASK))); // R6
  AST_HOLD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(ctrl_q)); // R8
endmodule

// File: rtl/wr_unlock_time_gate.sv
module wr_unlock_time_gate #(
  parameter int unsigned ADDR_W = 4,
  parameter logic [ADDR_W-1:0] TIME_ADDR = 4'h2
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              enable_i,
  output logic              time_we_o
);
  assign time_we_o = wr_en_i && (wr_addr_i == TIME_ADDR) && enable_i;
endmodule

// File: rtl/wr_unlock_guard.sv
module wr_unlock_guard #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned KEY_W     = 8,
  parameter int unsigned GUARD_BIT = 13,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'h0,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 4'h1,
  parameter logic [ADDR_W-1:0] TIME_ADDR = 4'h2,
  parameter logic [KEY_W-1:0]  KEY_A     = 8'h55,
  parameter logic [KEY_W-1:0]  KEY_B     = 8'hAA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              time_wr_en_o,
  output logic              time_we_o
);
  logic open;

  wr_unlock_key_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_W(KEY_W),
    .KEY_ADDR(KEY_ADDR), .KEY_A(KEY_A), .KEY_B(KEY_B)
  ) u_key_fsm (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .open_o(open)
  );

  wr_unlock_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GUARD_BIT(GUARD_BIT), .CTRL_ADDR(CTRL_ADDR)
  ) u_ctrl_reg (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .open_i(open),
    .ctrl_o(ctrl_o)
  );

  assign time_wr_en_o = ctrl_o[GUARD_BIT];

  wr_unlock_time_gate #(.ADDR_W(ADDR_W), .TIME_ADDR(TIME_ADDR)) u_time_gate (
    .wr_en_i, .wr_addr_i,
    .enable_i(time_wr_en_o),
    .time_we_o(time_we_o)
  );

  AST_RESET_LOCKED: assert property (@(posedge clk_i)
    !rst_ni |=> !time_wr_en_o); // R1
  AST_TIME_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    time_we_o |-> (time_wr_en_o && wr_en_i)); // R7
endmodule

// File: tb/wr_unlock_guard_bench.sv
module wr_unlock_guard_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] ctrl;
  logic        en, twe;
  int vectors = 0;
  int miscompares = 0;

  localparam logic [3:0] A_CTRL = 4'h0, A_KEY = 4'h1, A_TIME = 4'h2;

  always #2 clk = ~clk;

  wr_unlock_guard u_wr_unlock_guard (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .ctrl_o(ctrl), .time_wr_en_o(en), .time_we_o(twe)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic lock();
    wr(A_CTRL, 16'h0000); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ctrl", ctrl, 16'h0);
    chk("R1 en", {15'b0, en}, 16'h0);
    chk("R1 twe", {15'b0, twe}, 16'h0);
    rst_n = 1'b1;
    // R1: idle after reset, so a lone 0xAA then a set does not unlock
    wr(A_KEY, 16'h00AA); wr(A_CTRL, 16'h2000); idle();
    chk("R1 idle seq", {15'b0, en}, 16'h0);

    // R2/R4: sweep every second-key value
    for (int v = 0; v < 256; v++) begin
      lock();
      wr(A_KEY, 16'h0055); wr(A_KEY, 16'(v)); wr(A_CTRL, 16'h2000); idle();
      chk(v == 'hAA ? "R2 second key" : "R4 wrong second key", {15'b0, en}, {15'b0, v == 'hAA});
    end
    // R2/R4: sweep every first-key value
    for (int v = 0; v < 256; v++) begin
      lock();
      wr(A_KEY, 16'(v)); wr(A_KEY, 16'h00AA); wr(A_CTRL, 16'h2000); idle();
      chk(v == 'h55 ? "R2 first key" : "R4 wrong first key", {15'b0, en}, {15'b0, v == 'h55});
    end
    // R2: upper key bits ignored
    lock();
    wr(A_KEY, 16'hFF55); wr(A_KEY, 16'h37AA); wr(A_CTRL, 16'h2000); idle();
    chk("R2 upper bits ignored", {15'b0, en}, 16'h1);
    // R2: idle gaps between keys allowed
    for (int g = 0; g < 4; g++) begin
      lock();
      wr(A_KEY, 16'h0055);
      for (int i = 0; i < g; i++) idle();
      wr(A_KEY, 16'h00AA); wr(A_CTRL, 16'h2000); idle();
      chk("R2 gap between keys", {15'b0, en}, 16'h1);
    end
    // R3/R4: gap after second key closes the window
    for (int g = 0; g < 4; g++) begin
      lock();
      wr(A_KEY, 16'h0055); wr(A_KEY, 16'h00AA);
      for (int i = 0; i < g; i++) idle();
      wr(A_CTRL, 16'h2000); idle();
      chk("R3 window one cycle", {15'b0, en}, {15'b0, g == 0});
    end
    // R4: other-address writes between keys abort
    for (int a = 0; a < 16; a++) begin
      if (a == A_KEY) continue;
      lock();
      wr(A_KEY, 16'h0055); wr(4'(a), 16'h0000); wr(A_KEY, 16'h00AA);
      wr(A_CTRL, 16'h2000); idle();
      chk("R4 interposed write", {15'b0, en}, 16'h0);
    end
    // R3: plain set attempt without keys
    lock();
    wr(A_CTRL, 16'h2000); idle();
    chk("R3 set without keys", ctrl, 16'h0000);

    // R6: other bits follow data while locked, bit 13 filtered
    for (int p = 0; p < 16; p++) begin
      logic [15:0] d;
      d = 16'h1 << p;
      d = d ^ 16'hA5C3;
      wr(A_CTRL, d); idle();
      chk("R6 locked write", ctrl, d & 16'hDFFF);
    end
    // R6/R3: unlocked write of all ones
    wr(A_KEY, 16'h0055); wr(A_KEY, 16'h00AA); wr(A_CTRL, 16'hFFFF); idle();
    chk("R6 unlocked write", ctrl, 16'hFFFF);
    // R8: key writes leave ctrl alone
    wr(A_KEY, 16'h0055); wr(A_KEY, 16'h1234); idle();
    chk("R8 key no effect", ctrl, 16'hFFFF);
    // R3: writing 1 while set keeps it, other bits updated
    wr(A_CTRL, 16'h2001); idle();
    chk("R3 hold while set", ctrl, 16'h2001);

    // R7: time write passes while set
    @(negedge clk); wr_en = 1'b1; wr_addr = A_TIME; wr_data = 16'h0042; #1;
    chk("R7 time write enabled", {15'b0, twe}, 16'h1);
    wr_addr = A_CTRL ^ 4'h8; #1;
    chk("R7 other address", {15'b0, twe}, 16'h0);
    idle(); #1;
    chk("R7 no write strobe", {15'b0, twe}, 16'h0);

    // R5: clear without keys
    wr(A_CTRL, 16'h0F00); idle();
    chk("R5 clear anytime", ctrl, 16'h0F00);
    @(negedge clk); wr_en = 1'b1; wr_addr = A_TIME; #1;
    chk("R7 time write blocked", {15'b0, twe}, 16'h0);
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule